// File: doc/BRIEF.md
# Word-Serial Multiply-Accumulate Unit with Hidden Carry Word

This execution unit carries out one fused step of a multiple-precision multiplication on a processor with W-bit words. Each step multiplies a W-bit source operand by an implicit multiplier register. It then adds a hidden carry word and the destination operand. The low W bits of the 2W-bit total go back as the new destination value. The high W bits stay inside the unit as the hidden carry word for the next step. A sequence of steps therefore produces one full row of partial products, one word per step, and the carry is never spilled to a general register.

The core supplies the source and destination values with an issue strobe. The unit returns the destination result on a write-back port two cycles later. The multiplier register is written through its own load port and holds its value between loads. A clear input zeroes the hidden carry word so that a new row starts from zero. While one step is in progress the unit raises busy, and an issue presented in that cycle is held off until the unit is free again.

Top module: `mac_unit`

## Requirements
- R1: The write-back value is bits [W-1:0] of rs*m + c + rd, where m is the multiplier register and c is the hidden carry word.
- R2: After each step the hidden carry word holds bits [2W-1:W] of that same total and feeds into the next step.
- R3: The total never exceeds 2^(2W)-1. With every input at its all-ones value the result word and the new carry word are both all-ones.
- R4: An issue sampled while busy_o is low is accepted. On the next clock edge busy_o rises, and on the edge after that wb_valid_o is high for exactly one cycle with the result.
- R5: busy_o stays high for exactly one cycle per step. An issue presented while busy_o is high is ignored at that edge and is accepted at the following edge if it is still held, so steps can start every two cycles.
- R6: carry_clr_i zeroes the hidden carry word. When the clear is given on the same edge that accepts an issue, that step sees a carry of zero. When a step completes on the same edge, the step's new carry word takes priority.
- R7: rc_load_i writes rc_data_i into the multiplier register, and the register otherwise keeps its value. A step uses the multiplier value held at the edge where it is accepted, so a load on that same edge applies only to later steps.
- R8: After reset busy_o and wb_valid_o are low, and the multiplier register and the hidden carry word are zero.
- R9: Steps chained row by row, with the carry cleared at the start of each row and drained at its end by a step with rs=0, give the exact product of two multiple-word operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Request to start one step |
| rs_i | input | W | Source operand |
| rd_i | input | W | Destination operand value in |
| busy_o | output | 1 | A step is in progress; new issues are held off |
| wb_valid_o | output | 1 | wb_data_o carries a result this cycle |
| wb_data_o | output | W | Low result word for the destination |
| rc_load_i | input | 1 | Load the multiplier register |
| rc_data_i | input | W | New multiplier value |
| carry_clr_i | input | 1 | Zero the hidden carry word |

## Verification
The hidden carry word cannot be seen directly at the ports. A wrong carry therefore shows only in the write-back word of the following step, one step (two cycles) later. In a chained row it also corrupts every higher word of the product. The multiplier register is also internal, so a load that lands on the wrong edge shows only as a wrong result in the first step that uses it. The bench exposes both registers through steps whose results depend on them: rd=0 with rs=0 returns the carry word, and rd=0 with rs=1 returns the multiplier plus the carry. A control error in the busy or valid sequencing appears at once, in the cycle right after the edge that accepted the issue.

// File: rtl/mac_pkg.sv
package mac_pkg;
    parameter int MAC_DEFAULT_W = 8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EXEC = 1'b1
    } mac_phase_e;
endpackage

// File: rtl/mac_pp_array.sv
module mac_pp_array #(
    parameter int W = mac_pkg::MAC_DEFAULT_W
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] partial [W+1];

    assign partial[0] = '0;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_row
            logic [PW-1:0] row;
            assign row = b_i[gi] ? ({{W{1'b0}}, a_i} << gi) : '0;
            assign partial[gi+1] = partial[gi] + row;
        end
    endgenerate

    assign prod_o = partial[W];
endmodule

// File: rtl/mac_acc_add.sv
module mac_acc_add #(
    parameter int W = mac_pkg::MAC_DEFAULT_W
) (
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   carry_i,
    input  logic [W-1:0]   dst_i,
    output logic [W-1:0]   lo_o,
    output logic [W-1:0]   hi_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] total;

    assign total = prod_i + {{W{1'b0}}, carry_i} + {{W{1'b0}}, dst_i};
    assign lo_o  = total[W-1:0];
    assign hi_o  = total[PW-1:W];
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int W = mac_pkg::MAC_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [W-1:0] rs_i,
    input  logic [W-1:0] rd_i,
    output logic         busy_o,
    output logic         wb_valid_o,
    output logic [W-1:0] wb_data_o,
    input  logic         rc_load_i,
    input  logic [W-1:0] rc_data_i,
    input  logic         carry_clr_i
);
    import mac_pkg::*;

    localparam int PW = 2 * W;

    typedef struct packed {
        mac_phase_e   phase;
        logic [W-1:0] op_rs;
        logic [W-1:0] op_rd;
        logic [W-1:0] op_rc;
        logic [W-1:0] rc;
        logic [W-1:0] exc;
        logic         wb_valid;
        logic [W-1:0] wb_data;
    } mac_state_t;

    mac_state_t state_d, state_q;

    logic [PW-1:0] prod;
    logic [W-1:0]  sum_lo, sum_hi;

    mac_pp_array #(.W(W)) u_pp (
        .a_i    (state_q.op_rs),
        .b_i    (state_q.op_rc),
        .prod_o (prod)
    );

    mac_acc_add #(.W(W)) u_add (
        .prod_i  (prod),
        .carry_i (state_q.exc),
        .dst_i   (state_q.op_rd),
        .lo_o    (sum_lo),
        .hi_o    (sum_hi)
    );

    always_comb begin
        state_d          = state_q;
        state_d.wb_valid = 1'b0;
        if (rc_load_i) begin
            state_d.rc = rc_data_i;
        end
        if (carry_clr_i) begin
            state_d.exc = '0;
        end
        case (state_q.phase)
            PH_IDLE: begin
                if (issue_i) begin
                    state_d.op_rs = rs_i;
                    state_d.op_rd = rd_i;
                    state_d.op_rc = state_q.rc;
                    state_d.phase = PH_EXEC;
                end
            end
            PH_EXEC: begin
                state_d.wb_data  = sum_lo;
                state_d.exc      = sum_hi;
                state_d.wb_valid = 1'b1;
                state_d.phase    = PH_IDLE;
            end
            default: state_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o     = (state_q.phase == PH_EXEC);
    assign wb_valid_o = state_q.wb_valid;
    assign wb_data_o  = state_q.wb_data;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue_i,
    input logic         rc_load_i,
    input logic         carry_clr_i,
    input logic         busy_o,
    input logic         wb_valid_o,
    input logic [W-1:0] exc_q,
    input logic [W-1:0] rc_q
);
    a_r4_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !busy_o) |=> busy_o);

    a_r5_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);

    a_r4_result_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> wb_valid_o);

    a_r4_result_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> $past(busy_o));

    a_r6_clear_zeroes_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_clr_i && !busy_o) |=> (exc_q == '0));

    a_r7_rc_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rc_load_i |=> $stable(rc_q));
endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_mac_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .rc_load_i   (rc_load_i),
    .carry_clr_i (carry_clr_i),
    .busy_o      (busy_o),
    .wb_valid_o  (wb_valid_o),
    .exc_q       (state_q.exc),
    .rc_q        (state_q.rc)
);

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_i = 1'b0;
    logic [W-1:0] rs_i = '0;
    logic [W-1:0] rd_i = '0;
    logic         busy_o;
    logic         wb_valid_o;
    logic [W-1:0] wb_data_o;
    logic         rc_load_i = 1'b0;
    logic [W-1:0] rc_data_i = '0;
    logic         carry_clr_i = 1'b0;

    int total = 0;
    int bad = 0;
    logic [W-1:0] m_rc = '0;
    logic [W-1:0] m_exc = '0;

    always #5 clk = ~clk;

    mac_unit #(.W(W)) u_mac_unit (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .rs_i(rs_i), .rd_i(rd_i),
        .busy_o(busy_o), .wb_valid_o(wb_valid_o), .wb_data_o(wb_data_o),
        .rc_load_i(rc_load_i), .rc_data_i(rc_data_i), .carry_clr_i(carry_clr_i)
    );

    function automatic logic [2*W-1:0] ref_total(input logic [W-1:0] a, m, c, d);
        return ({{W{1'b0}}, a} * {{W{1'b0}}, m}) + {{W{1'b0}}, c} + {{W{1'b0}}, d};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic load_rc(input logic [W-1:0] v);
        @(negedge clk);
        rc_load_i = 1'b1; rc_data_i = v;
        @(posedge clk);
        @(negedge clk);
        rc_load_i = 1'b0;
        m_rc = v;
    endtask

    // one step: optional clear and load on the accepting edge
    task automatic step(input string tag, input logic [W-1:0] a, input logic [W-1:0] d,
                        input bit clr, input bit ld, input logic [W-1:0] ldv,
                        output logic [W-1:0] res);
        logic [2*W-1:0] t;
        @(negedge clk);
        issue_i = 1'b1; rs_i = a; rd_i = d; carry_clr_i = clr;
        rc_load_i = ld; rc_data_i = ldv;
        if (clr) m_exc = '0;
        t = ref_total(a, m_rc, m_exc, d);
        if (ld) m_rc = ldv;
        @(posedge clk);
        @(negedge clk);
        issue_i = 1'b0; carry_clr_i = 1'b0; rc_load_i = 1'b0;
        check({tag, " R4 busy"}, {7'd0, busy_o}, 8'd1);
        check({tag, " R4 no early valid"}, {7'd0, wb_valid_o}, 8'd0);
        @(posedge clk);
        @(negedge clk);
        check({tag, " R4 valid"}, {7'd0, wb_valid_o}, 8'd1);
        check({tag, " R5 busy drops"}, {7'd0, busy_o}, 8'd0);
        check({tag, " R1 result"}, wb_data_o, t[W-1:0]);
        m_exc = t[2*W-1:W];
        res = wb_data_o;
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] r;
        logic [2*W-1:0] t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        check("R8 busy", {7'd0, busy_o}, 8'd0);
        check("R8 valid", {7'd0, wb_valid_o}, 8'd0);
        step("R8 zero rc and carry", 8'h05, 8'h03, 0, 0, 0, r);
        check("R8 rd passes", r, 8'h03);
        step("R8 carry zero", 8'h00, 8'h00, 0, 0, 0, r);
        check("R8 drained carry", r, 8'h00);

        // R1 R2 basic
        load_rc(8'hA7);
        step("R1 a", 8'h3C, 8'h11, 1, 0, 0, r);
        step("R2 carry used", 8'h00, 8'h00, 0, 0, 0, r);
        check("R2 carry word", r, ref_total(8'h3C, 8'hA7, 8'h00, 8'h11) >> W);

        // R3 all ones
        load_rc(8'hFF);
        step("R3 prime", 8'hFF, 8'hFF, 1, 0, 0, r);
        step("R3 max", 8'hFF, 8'hFF, 0, 0, 0, r);
        check("R3 low max", r, 8'hFF);
        step("R3 drain", 8'h00, 8'h00, 0, 0, 0, r);
        check("R3 high max", r, 8'hFF);

        // R6 clear while idle, then step
        step("R6 set carry", 8'hF0, 8'h00, 0, 0, 0, r);
        @(negedge clk); carry_clr_i = 1'b1;
        @(posedge clk); @(negedge clk); carry_clr_i = 1'b0;
        m_exc = '0;
        step("R6 after idle clear", 8'h00, 8'h00, 0, 0, 0, r);
        check("R6 carry gone", r, 8'h00);

        // R7 load on accepting edge uses old value
        load_rc(8'h21);
        step("R7 old rc", 8'h01, 8'h00, 1, 1, 8'h80, r);
        check("R7 old rc used", r, 8'h21);
        step("R7 new rc", 8'h01, 8'h00, 1, 0, 0, r);
        check("R7 new rc held", r, 8'h80);

        // R5 issue held during busy is stalled then accepted
        load_rc(8'h13);
        @(negedge clk);
        m_exc = '0;
        issue_i = 1'b1; rs_i = 8'h22; rd_i = 8'h01; carry_clr_i = 1'b1;
        @(posedge clk); @(negedge clk);
        carry_clr_i = 1'b0; rs_i = 8'h77; rd_i = 8'h05;
        check("R5 busy while held", {7'd0, busy_o}, 8'd1);
        @(posedge clk); @(negedge clk);
        t = ref_total(8'h22, 8'h13, 8'h00, 8'h01);
        check("R5 first result", wb_data_o, t[W-1:0]);
        check("R5 free", {7'd0, busy_o}, 8'd0);
        m_exc = t[2*W-1:W];
        @(posedge clk); @(negedge clk);
        issue_i = 1'b0;
        check("R5 second accepted", {7'd0, busy_o}, 8'd1);
        @(posedge clk); @(negedge clk);
        t = ref_total(8'h77, 8'h13, m_exc, 8'h05);
        check("R5 second result", wb_data_o, t[W-1:0]);
        m_exc = t[2*W-1:W];

        // random steps
        for (int i = 0; i < 150; i++) begin
            logic [W-1:0] ra, rd, lv;
            bit c, l;
            ra = $urandom(); rd = $urandom(); lv = $urandom();
            c = ($urandom() % 4) == 0; l = ($urandom() % 5) == 0;
            step("R1 random", ra, rd, c, l, lv, r);
        end

        // R9 full 8x8-word product
        for (int n = 0; n < 4; n++) begin
            logic [63:0] a, b;
            logic [127:0] p, exp_p;
            logic [7:0] acc [16];
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            if (n == 0) begin a = '1; b = '1; end
            for (int k = 0; k < 16; k++) acc[k] = '0;
            for (int i = 0; i < 8; i++) begin
                load_rc(b[i*8 +: 8]);
                for (int j = 0; j < 8; j++) begin
                    step("R9 row", a[j*8 +: 8], acc[i+j], j == 0, 0, 0, r);
                    acc[i+j] = r;
                end
                step("R9 drain", 8'h00, acc[i+8], 0, 0, 0, r);
                acc[i+8] = r;
            end
            for (int k = 0; k < 16; k++) p[k*8 +: 8] = acc[k];
            exp_p = {64'd0, a} * {64'd0, b};
            total++;
            if (p !== exp_p) begin
                bad++;
                $display("FAIL R9 product got=%0h expected=%0h", p, exp_p);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule